// File: doc/BRIEF.md
# Accumulator Datapath with Link Bit

This block holds the working accumulator of a small word-oriented processor together with its one-bit link (carry) flag. Each cycle, a set of one-hot operation strobes from the instruction sequencer picks one change to the accumulator. The change can be a bitwise AND or a sum with a 16-bit operand word, a copy of that operand, an 8-bit character merge into the low byte, an inversion, a one-place rotate through the link bit, an increment, or a clear. The link bit takes the carry out of the sum and the bit shifted out by a rotate. Two further strobes clear or invert it directly.

The next accumulator value is formed by a chain of identical bit slices. Each slice picks its own result from the operand bit, its neighbours, the character bit and the ripple carry. A small control stage turns the strobes into three register controls: load, increment and clear. Only one of them is active at a time. Zero and negative flags are taken straight from the register, so the sequencer can test for skip conditions.

Top module: `acc_unit`

## Requirements
- R1: After reset the accumulator is 0000h and the link bit is 0.
- R2: The AND strobe (bit 0 of the bench's op vector) loads acc AND operand, leaving the link bit unchanged.
- R3: The ADD strobe (bit 1) loads the low 16 bits of acc + operand and writes the carry out of bit 15 into the link bit.
- R4: The operand-load strobe (bit 2) copies the operand into the accumulator, leaving the link bit unchanged.
- R5: The character strobe (bit 3) replaces acc[7:0] with the 8-bit character; acc[15:8] and the link bit are unchanged.
- R6: The invert strobe (bit 4) inverts all accumulator bits, leaving the link bit unchanged.
- R7: The right-rotate strobe (bit 5) moves the link bit into acc[15], shifts acc[15:1] into acc[14:0], and moves the old acc[0] into the link bit.
- R8: The left-rotate strobe (bit 6) moves the link bit into acc[0], shifts acc[14:0] into acc[15:1], and moves the old acc[15] into the link bit.
- R9: The increment strobe (bit 7) adds one with wrap from FFFFh to 0000h and never changes the link bit.
- R10: The clear strobe (bit 8) sets the accumulator to 0000h and leaves the link bit unchanged.
- R11: When several strobes are active, clear wins over increment, which wins over every data strobe. A data strobe that loses makes no change to the accumulator or the link bit.
- R12: zero_o is 1 exactly when the accumulator is 0000h, and neg_o equals acc[15], both without delay.
- R13: link_clr_i clears the link bit and link_inv_i inverts it. link_clr_i wins over link_inv_i, and an executing ADD or rotate overrides both.
- R14: With no strobe active, the accumulator and link bit hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_and_i | input | 1 | AND accumulator with operand |
| op_add_i | input | 1 | Add operand, carry to link |
| op_ldd_i | input | 1 | Load operand |
| op_chr_i | input | 1 | Merge character into low byte |
| op_inv_i | input | 1 | Invert accumulator |
| op_ror_i | input | 1 | Rotate right through link |
| op_rol_i | input | 1 | Rotate left through link |
| op_inc_i | input | 1 | Increment accumulator |
| op_clr_i | input | 1 | Clear accumulator |
| link_clr_i | input | 1 | Clear link bit |
| link_inv_i | input | 1 | Invert link bit |
| opnd_i | input | 16 | Operand word |
| chr_i | input | 8 | Input character |
| acc_o | output | 16 | Accumulator |
| link_o | output | 1 | Link bit |
| zero_o | output | 1 | Accumulator is zero |
| neg_o | output | 1 | Accumulator sign bit |

## Verification
Each per-operation assertion takes for granted that its strobe is the only active one among the nine. The priority rules are checked by separate assertions that need only clear, or increment without clear, to be present. The directed stimulus keeps to single strobes, apart from the priority scenario. That scenario deliberately raises several strobes together, so only the priority assertions and the bench checks judge it. The link-strobe assertions assume that no ADD or rotate executes in the same cycle, and the bench drives them alone.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef struct packed {
    logic f_clr;
    logic f_inc;
    logic f_rol;
    logic f_ror;
    logic f_inv;
    logic f_chr;
    logic f_ldd;
    logic f_add;
    logic f_and;
  } acc_ops_t;

  localparam int unsigned NUM_OPS = 9;
endpackage

// File: rtl/acc_ctl.sv
module acc_ctl
  import acc_pkg::*;
(
  input  acc_ops_t ops_i,
  output logic     ld_o,
  output logic     inr_o,
  output logic     clr_o,
  output acc_ops_t sel_o
);
  logic any_data;

  assign any_data = ops_i.f_and | ops_i.f_add | ops_i.f_ldd | ops_i.f_chr |
                    ops_i.f_inv | ops_i.f_ror | ops_i.f_rol;
  assign clr_o = ops_i.f_clr;
  assign inr_o = ops_i.f_inc & ~ops_i.f_clr;
  assign ld_o  = any_data & ~ops_i.f_inc & ~ops_i.f_clr;

  // fixed pick among data strobes so the slices see a one-hot select
  always_comb begin
    sel_o = '0;
    if (ld_o) begin
      if      (ops_i.f_and) sel_o.f_and = 1'b1;
      else if (ops_i.f_add) sel_o.f_add = 1'b1;
      else if (ops_i.f_ldd) sel_o.f_ldd = 1'b1;
      else if (ops_i.f_chr) sel_o.f_chr = 1'b1;
      else if (ops_i.f_inv) sel_o.f_inv = 1'b1;
      else if (ops_i.f_ror) sel_o.f_ror = 1'b1;
      else                  sel_o.f_rol = 1'b1;
    end
  end
endmodule

// File: rtl/acc_slice.sv
module acc_slice
  import acc_pkg::*;
#(
  parameter bit HAS_CHR = 1'b1
) (
  input  acc_ops_t sel_i,
  input  logic     a_i,
  input  logic     d_i,
  input  logic     chr_i,
  input  logic     from_hi_i,
  input  logic     from_lo_i,
  input  logic     cin_i,
  output logic     nxt_o,
  output logic     cout_o
);
  logic chr_bit;

  generate
    if (HAS_CHR) begin : g_chr
      assign chr_bit = chr_i;
    end else begin : g_keep
      assign chr_bit = a_i;
    end
  endgenerate

  assign cout_o = (a_i & d_i) | (cin_i & (a_i ^ d_i));

  always_comb begin
    unique case (1'b1)
      sel_i.f_and: nxt_o = a_i & d_i;
      sel_i.f_add: nxt_o = a_i ^ d_i ^ cin_i;
      sel_i.f_ldd: nxt_o = d_i;
      sel_i.f_chr: nxt_o = chr_bit;
      sel_i.f_inv: nxt_o = ~a_i;
      sel_i.f_ror: nxt_o = from_hi_i;
      sel_i.f_rol: nxt_o = from_lo_i;
      default:     nxt_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 8
) (
  input  acc_ops_t       sel_i,
  input  logic [W-1:0]   acc_i,
  input  logic           link_i,
  input  logic [W-1:0]   opnd_i,
  input  logic [CW-1:0]  chr_i,
  output logic [W-1:0]   nxt_o,
  output logic           link_nxt_o,
  output logic           link_wr_o
);
  localparam int unsigned MSB = W - 1;

  logic [W:0] carry;
  assign carry[0] = 1'b0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic hi_n, lo_n, chr_b;
      if (i == MSB) begin : g_top
        assign hi_n = link_i;
      end else begin : g_mid_hi
        assign hi_n = acc_i[i+1];
      end
      if (i == 0) begin : g_bot
        assign lo_n = link_i;
      end else begin : g_mid_lo
        assign lo_n = acc_i[i-1];
      end
      if (i < CW) begin : g_c
        assign chr_b = chr_i[i];
      end else begin : g_nc
        assign chr_b = 1'b0;
      end
      acc_slice #(.HAS_CHR(i < CW)) u_slice (
        .sel_i     (sel_i),
        .a_i       (acc_i[i]),
        .d_i       (opnd_i[i]),
        .chr_i     (chr_b),
        .from_hi_i (hi_n),
        .from_lo_i (lo_n),
        .cin_i     (carry[i]),
        .nxt_o     (nxt_o[i]),
        .cout_o    (carry[i+1])
      );
    end
  endgenerate

  assign link_wr_o = sel_i.f_add | sel_i.f_ror | sel_i.f_rol;

  always_comb begin
    link_nxt_o = link_i;
    if      (sel_i.f_add) link_nxt_o = carry[W];
    else if (sel_i.f_ror) link_nxt_o = acc_i[0];
    else if (sel_i.f_rol) link_nxt_o = acc_i[MSB];
  end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_and_i,
  input  logic          op_add_i,
  input  logic          op_ldd_i,
  input  logic          op_chr_i,
  input  logic          op_inv_i,
  input  logic          op_ror_i,
  input  logic          op_rol_i,
  input  logic          op_inc_i,
  input  logic          op_clr_i,
  input  logic          link_clr_i,
  input  logic          link_inv_i,
  input  logic [W-1:0]  opnd_i,
  input  logic [CW-1:0] chr_i,
  output logic [W-1:0]  acc_o,
  output logic          link_o,
  output logic          zero_o,
  output logic          neg_o
);
  acc_ops_t ops, sel;
  logic ld, inr, clr;
  logic [W-1:0] alu_nxt;
  logic alu_link, alu_link_wr;
  logic [W-1:0] acc_q;
  logic link_q;

  assign ops = '{f_clr: op_clr_i, f_inc: op_inc_i, f_rol: op_rol_i,
                 f_ror: op_ror_i, f_inv: op_inv_i, f_chr: op_chr_i,
                 f_ldd: op_ldd_i, f_add: op_add_i, f_and: op_and_i};

  acc_ctl u_ctl (
    .ops_i (ops),
    .ld_o  (ld),
    .inr_o (inr),
    .clr_o (clr),
    .sel_o (sel)
  );

  acc_alu #(.W(W), .CW(CW)) u_alu (
    .sel_i      (sel),
    .acc_i      (acc_q),
    .link_i     (link_q),
    .opnd_i     (opnd_i),
    .chr_i      (chr_i),
    .nxt_o      (alu_nxt),
    .link_nxt_o (alu_link),
    .link_wr_o  (alu_link_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (inr) acc_q <= acc_q + 1'b1;
    else if (ld)  acc_q <= alu_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  link_q <= 1'b0;
    else if (ld && alu_link_wr)   link_q <= alu_link;
    else if (link_clr_i)          link_q <= 1'b0;
    else if (link_inv_i)          link_q <= ~link_q;
  end

  assign acc_o  = acc_q;
  assign link_o = link_q;
  assign zero_o = ~|acc_q;
  assign neg_o  = acc_q[W-1];

  // assertion helpers
  logic solo;
  logic link_quiet;
  assign solo       = ($countones(ops) == 1);
  assign link_quiet = !(op_add_i | op_ror_i | op_rol_i | op_inc_i | op_clr_i |
                        op_and_i | op_ldd_i | op_chr_i | op_inv_i);

  assert_and_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo && op_and_i && !link_clr_i && !link_inv_i)
      |=> (acc_o == ($past(acc_o) & $past(opnd_i))) && $stable(link_o));

  assert_add_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo && op_add_i)
      |=> ({link_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(opnd_i)})));

  assert_chr_hi_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo && op_chr_i)
      |=> (acc_o[W-1:CW] == $past(acc_o[W-1:CW])) && (acc_o[CW-1:0] == $past(chr_i)));

  assert_ror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo && op_ror_i)
      |=> ({acc_o, link_o} == {$past(link_o), $past(acc_o)}));

  assert_rol_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo && op_rol_i)
      |=> ({link_o, acc_o} == {$past(acc_o), $past(link_o)}));

  assert_inc_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_inc_i && !op_clr_i && !link_clr_i && !link_inv_i)
      |=> (acc_o == $past(acc_o) + 1'b1) && $stable(link_o));

  assert_clr_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_clr_i && !link_clr_i && !link_inv_i) |=> (acc_o == '0) && $stable(link_o));

  assert_link_clr_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_quiet && link_clr_i) |=> !link_o);

  assert_link_inv_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_quiet && link_inv_i && !link_clr_i) |=> (link_o != $past(link_o)));

  assert_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_quiet && !link_clr_i && !link_inv_i) |=> $stable(acc_o) && $stable(link_o));
endmodule

// File: tb/tb_acc_unit.sv
module tb_acc_unit;
  localparam int CLK_PERIOD = 10;

  localparam logic [8:0] OP_AND = 9'h001;
  localparam logic [8:0] OP_ADD = 9'h002;
  localparam logic [8:0] OP_LDD = 9'h004;
  localparam logic [8:0] OP_CHR = 9'h008;
  localparam logic [8:0] OP_INV = 9'h010;
  localparam logic [8:0] OP_ROR = 9'h020;
  localparam logic [8:0] OP_ROL = 9'h040;
  localparam logic [8:0] OP_INC = 9'h080;
  localparam logic [8:0] OP_CLR = 9'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] ops = '0;
  logic lclr = 1'b0, linv = 1'b0;
  logic [15:0] opnd = '0;
  logic [7:0] chr = '0;
  logic [15:0] acc;
  logic link, zero, neg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_and_i(ops[0]), .op_add_i(ops[1]), .op_ldd_i(ops[2]), .op_chr_i(ops[3]),
    .op_inv_i(ops[4]), .op_ror_i(ops[5]), .op_rol_i(ops[6]), .op_inc_i(ops[7]),
    .op_clr_i(ops[8]), .link_clr_i(lclr), .link_inv_i(linv),
    .opnd_i(opnd), .chr_i(chr),
    .acc_o(acc), .link_o(link), .zero_o(zero), .neg_o(neg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock with the given strobes, inputs dropped before checking
  task automatic step(input logic [8:0] o, input logic [15:0] d, input logic [7:0] c,
                      input logic lc, input logic li);
    @(negedge clk);
    ops = o; opnd = d; chr = c; lclr = lc; linv = li;
    @(negedge clk);
    ops = '0; lclr = 1'b0; linv = 1'b0;
  endtask

  task automatic preset(input logic [15:0] v, input logic l);
    step(OP_LDD, v, 8'h00, 1'b1, 1'b0);
    if (l) step('0, 16'h0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 acc", acc, 0);
    chk("R1 link", link, 0);
    chk("R12 zero at reset", zero, 1);
    chk("R12 neg at reset", neg, 0);
  endtask

  task automatic t_load_and;
    preset(16'h1234, 1'b1);
    chk("R4 load", acc, 16'h1234);
    chk("R4 link kept", link, 1);
    step(OP_AND, 16'h0F0F, 8'h00, 1'b0, 1'b0);
    chk("R2 and", acc, 16'h0204);
    chk("R2 link kept", link, 1);
  endtask

  task automatic t_add;
    preset(16'hFFFF, 1'b0);
    step(OP_ADD, 16'h0001, 8'h00, 1'b0, 1'b0);
    chk("R3 sum wrap", acc, 16'h0000);
    chk("R3 carry set", link, 1);
    chk("R12 zero", zero, 1);
    preset(16'h1234, 1'b1);
    step(OP_ADD, 16'h4321, 8'h00, 1'b0, 1'b0);
    chk("R3 sum", acc, 16'h5555);
    chk("R3 carry clear", link, 0);
  endtask

  task automatic t_chr_inv;
    preset(16'h12CD, 1'b1);
    step(OP_CHR, 16'hFFFF, 8'hAB, 1'b0, 1'b0);
    chk("R5 merge", acc, 16'h12AB);
    chk("R5 link kept", link, 1);
    step(OP_INV, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R6 invert", acc, 16'hED54);
    chk("R6 link kept", link, 1);
    chk("R12 neg", neg, 1);
    chk("R12 nonzero", zero, 0);
  endtask

  task automatic t_rotate;
    preset(16'h0001, 1'b1);
    step(OP_ROR, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R7 acc", acc, 16'h8000);
    chk("R7 link", link, 1);
    preset(16'h8000, 1'b0);
    step(OP_ROL, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R8 acc", acc, 16'h0000);
    chk("R8 link", link, 1);
    preset(16'h4002, 1'b0);
    step(OP_ROL, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R8 shift", acc, 16'h8004);
    chk("R8 link out", link, 0);
  endtask

  task automatic t_inc_clr;
    preset(16'hFFFF, 1'b1);
    step(OP_INC, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R9 wrap", acc, 16'h0000);
    chk("R9 link kept", link, 1);
    step(OP_INC, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R9 inc", acc, 16'h0001);
    preset(16'hBEEF, 1'b1);
    step(OP_CLR, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R10 clear", acc, 0);
    chk("R10 link kept", link, 1);
  endtask

  task automatic t_priority;
    preset(16'hFFFF, 1'b0);
    step(OP_CLR | OP_INC | OP_ADD, 16'h0001, 8'h00, 1'b0, 1'b0);
    chk("R11 clear wins", acc, 0);
    chk("R11 add lost link", link, 0);
    preset(16'h8000, 1'b0);
    step(OP_INC | OP_ROL, 16'h0, 8'h00, 1'b0, 1'b0);
    chk("R11 inc wins", acc, 16'h8001);
    chk("R11 rol lost link", link, 0);
  endtask

  task automatic t_link;
    preset(16'h0123, 1'b0);
    step('0, 16'h0, 8'h00, 1'b0, 1'b1);
    chk("R13 invert", link, 1);
    step('0, 16'h0, 8'h00, 1'b1, 1'b1);
    chk("R13 clear over invert", link, 0);
    preset(16'hFFFF, 1'b0);
    step(OP_ADD, 16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R13 add over clear", link, 1);
    step('0, 16'hFFFF, 8'hFF, 1'b0, 1'b0);
    chk("R14 hold acc", acc, 16'h0000);
    chk("R14 hold link", link, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and();
    t_add();
    t_chr_inv();
    t_rotate();
    t_inc_clr();
    t_priority();
    t_link();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule